// File: doc/BRIEF.md
# Half-Period Bin Timer with Interrupts

This block produces the drive timing for a resonant actuator from a slow timing tick (nominally 125 kHz, so one tick every 8 µs). Software programs a half-period length in ticks, which is the tick rate divided by twice the resonant frequency. Each half-cycle is divided into eight bins. The block keeps a running bin index from 0 to 15 over a full period: bins 0 to 7 form the first half-cycle and bins 8 to 15 the second. The square-wave drive polarity follows the half-cycle, and an invert input flips it so that the actuator can be braked quickly.

An interrupt can be placed at a chosen bin. An index below 8 selects the same position in both half-cycles. An index of 8 or more selects one position in the second half-cycle only. A period divider lets only one period in N raise interrupts. Each interrupt is a one-cycle pulse that also sets a sticky flag, which software clears by writing one. Software can read the bin index and compare it with the interrupt index when it updates the half-period. A new half-period value takes effect at the next half-cycle boundary, so it never shortens a half-cycle that is already running.

Top module: `hp_bin_timer`

## Requirements
- R1: During reset, and on every clock while `en_i` is low, `bin_idx_o` is 0 and `bin_stb_o` and `irq_pulse_o` are 0. Reset also clears `irq_flag_o`.
- R2: While enabled, the tick counter advances once per clock with `tick_i` high. Each of bins 0 to 6 of a half-cycle lasts floor(H/8) ticks. Bin 7 of the half-cycle lasts floor(H/8) + (H mod 8) ticks, where H is the active half-period. The index wraps from 15 to 0.
- R3: A half-period input below 8 is treated as 8.
- R4: The active half-period is loaded from `half_period_i` while disabled and at each half-cycle boundary (leaving bin 7 or bin 15). A change in the middle of a half-cycle does not alter that half-cycle.
- R5: `bin_stb_o` is high for exactly the first clock in which a new `bin_idx_o` value is visible.
- R6: `drive_pol_o` equals bit 3 of `bin_idx_o` (0 in the first half-cycle, 1 in the second), XORed with `pol_inv_i`.
- R7: An interrupt fires on entry into bin b when `irq_idx_i` < 8 and b mod 8 equals `irq_idx_i`, or when `irq_idx_i` >= 8 and b equals `irq_idx_i`. It appears on `irq_pulse_o` in the same clock as that bin's strobe.
- R8: A period counter starts at 0 on enable and advances on each entry into bin 0, wrapping when it reaches `irq_div_i`. Values 0 and 1 mean every period. Interrupts fire only while the counter is 0.
- R9: With `irq_en_i` low at the entering tick, no interrupt pulse is raised.
- R10: `irq_flag_o` is set by an interrupt pulse in the same clock and cleared by `irq_clr_i` high. When both occur in the same clock, setting wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-clock timing tick, nominally 125 kHz |
| en_i | input | 1 | Timer enable; low holds the timer at bin 0 |
| half_period_i | input | HPW | Half-period length in ticks |
| irq_idx_i | input | 4 | Interrupt bin index |
| irq_div_i | input | DIVW | Period divider for interrupts |
| pol_inv_i | input | 1 | Inverts the drive polarity |
| irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Write-one-to-clear for the sticky flag |
| bin_idx_o | output | 4 | Current bin index 0 to 15 |
| bin_stb_o | output | 1 | Pulse on each bin change |
| drive_pol_o | output | 1 | Square-wave drive polarity |
| irq_pulse_o | output | 1 | One-clock interrupt pulse |
| irq_flag_o | output | 1 | Sticky interrupt flag |

## Verification
The timer is run with a half-period that is not a multiple of 8 (20 ticks), which shows whether the remainder lands in the last bin of each half-cycle. A value below 8 shows the clamp. A half-period rewrite in the middle of a half-cycle shows whether loading waits for the half-cycle boundary. The interrupt is tried with an index below 8 (two hits per period) and one above 8 (one hit). With a divider of 3, every third period must raise interrupts. With the interrupt enable low, nothing must fire. A behavioural model compares every output on every clock, and pulse counts over fixed tick windows are checked against hand-computed totals.

// File: rtl/hbt_pkg.sv
package hbt_pkg;
  localparam int unsigned BINS_PER_HALF = 8;
  localparam int unsigned MIN_HP        = BINS_PER_HALF;

  // half-period after clamping to at least one tick per bin
  function automatic int unsigned hbt_eff_hp(int unsigned hp);
    return (hp < MIN_HP) ? MIN_HP : hp;
  endfunction

  // ticks spent in a bin; the final bin of a half absorbs the remainder
  function automatic int unsigned hbt_bin_len(int unsigned hp, logic [2:0] sub);
    int unsigned base;
    base = hp / BINS_PER_HALF;
    return (sub == 3'd7) ? (hp - 7 * base) : base;
  endfunction

  // interrupt position match for a bin being entered
  function automatic logic hbt_irq_hit(logic [3:0] bin, logic [3:0] idx);
    return idx[3] ? (bin == idx) : (bin[2:0] == idx[2:0]);
  endfunction
endpackage

// File: rtl/hbt_bin_seq.sv
module hbt_bin_seq
  import hbt_pkg::*;
#(
  parameter int HPW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_i,
  input  logic           en_i,
  input  logic [HPW-1:0] hp_i,
  output logic [3:0]     bin_o,
  output logic           stb_o,
  output logic           adv_o,
  output logic [3:0]     nxt_bin_o
);
  logic [HPW-1:0] hp_act;
  logic [HPW-1:0] cnt;
  logic [HPW-1:0] len;
  logic [HPW-1:0] hp_load;
  logic           half_end;

  assign hp_load   = HPW'(hbt_eff_hp(32'(hp_i)));
  assign len       = HPW'(hbt_bin_len(32'(hp_act), bin_o[2:0]));
  assign adv_o     = en_i && tick_i && (({1'b0, cnt} + 1'b1) >= {1'b0, len});
  assign nxt_bin_o = bin_o + 4'd1;
  assign half_end  = adv_o && (bin_o[2:0] == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp_act <= HPW'(MIN_HP);
      cnt    <= '0;
      bin_o  <= '0;
      stb_o  <= 1'b0;
    end else if (!en_i) begin
      hp_act <= hp_load;
      cnt    <= '0;
      bin_o  <= '0;
      stb_o  <= 1'b0;
    end else begin
      stb_o <= adv_o;
      if (adv_o) begin
        cnt   <= '0;
        bin_o <= nxt_bin_o;
      end else if (tick_i) begin
        cnt <= cnt + 1'b1;
      end
      if (half_end) hp_act <= hp_load;
    end
  end

  // R5
  stb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |-> (bin_o == $past(bin_o) + 4'd1));

  // R2
  bin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && $past(en_i) && !stb_o) |-> $stable(bin_o));

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_i) |-> (bin_o == 4'd0 && !stb_o));
endmodule

// File: rtl/hbt_irq_gen.sv
module hbt_irq_gen
  import hbt_pkg::*;
#(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            adv_i,
  input  logic [3:0]      nxt_bin_i,
  input  logic [3:0]      idx_i,
  input  logic [DIVW-1:0] div_i,
  input  logic            irq_en_i,
  input  logic            clr_i,
  input  logic            stb_i,
  output logic            pulse_o,
  output logic            flag_o
);
  logic [DIVW-1:0] pcnt_q;
  logic [DIVW-1:0] pcnt_d;
  logic [DIVW:0]   pcnt_inc;
  logic            wrap;
  logic            fire;

  assign wrap     = adv_i && (nxt_bin_i == 4'd0);
  assign pcnt_inc = {1'b0, pcnt_q} + 1'b1;

  always_comb begin
    pcnt_d = pcnt_q;
    if (wrap) pcnt_d = (pcnt_inc >= {1'b0, div_i}) ? '0 : pcnt_inc[DIVW-1:0];
  end

  assign fire = adv_i && irq_en_i && hbt_irq_hit(nxt_bin_i, idx_i) && (pcnt_d == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q  <= '0;
      pulse_o <= 1'b0;
      flag_o  <= 1'b0;
    end else begin
      pcnt_q  <= en_i ? pcnt_d : '0;
      pulse_o <= en_i && fire;
      flag_o  <= (en_i && fire) || (flag_o && !clr_i);
    end
  end

  // R7
  irq_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> stb_i);

  // R9
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> $past(irq_en_i));

  // R8
  irq_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> (pcnt_q == '0));

  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> flag_o);
endmodule

// File: rtl/hp_bin_timer.sv
module hp_bin_timer
  import hbt_pkg::*;
#(
  parameter int HPW  = 16,
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            en_i,
  input  logic [HPW-1:0]  half_period_i,
  input  logic [3:0]      irq_idx_i,
  input  logic [DIVW-1:0] irq_div_i,
  input  logic            pol_inv_i,
  input  logic            irq_en_i,
  input  logic            irq_clr_i,
  output logic [3:0]      bin_idx_o,
  output logic            bin_stb_o,
  output logic            drive_pol_o,
  output logic            irq_pulse_o,
  output logic            irq_flag_o
);
  logic       bin_adv;
  logic [3:0] bin_nxt;

  hbt_bin_seq #(.HPW(HPW)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .en_i      (en_i),
    .hp_i      (half_period_i),
    .bin_o     (bin_idx_o),
    .stb_o     (bin_stb_o),
    .adv_o     (bin_adv),
    .nxt_bin_o (bin_nxt)
  );

  hbt_irq_gen #(.DIVW(DIVW)) irq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .adv_i     (bin_adv),
    .nxt_bin_i (bin_nxt),
    .idx_i     (irq_idx_i),
    .div_i     (irq_div_i),
    .irq_en_i  (irq_en_i),
    .clr_i     (irq_clr_i),
    .stb_i     (bin_stb_o),
    .pulse_o   (irq_pulse_o),
    .flag_o    (irq_flag_o)
  );

  assign drive_pol_o = bin_idx_o[3] ^ pol_inv_i;

  // R6
  pol_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_stb_o && bin_idx_o == 4'd8) |-> (drive_pol_o != $past(drive_pol_o) || pol_inv_i != $past(pol_inv_i)));
endmodule

// File: tb/hp_bin_timer_tb_top.sv
module hp_bin_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, en = 1'b0, pinv = 1'b0, ien = 1'b0, clr = 1'b0;
  logic [15:0] hp = 16'd20;
  logic [3:0]  idx = 4'd0;
  logic [7:0]  dv = 8'd1;
  logic [3:0]  bin;
  logic        stb, pol, irq, flag;

  int total = 0, bad = 0;
  int irq_seen = 0, stb_seen = 0;
  int m_bin = 0, m_cnt = 0, m_pc = 0, m_hp = 8, m_stb = 0, m_irq = 0, m_flag = 0;

  always #10 clk = ~clk;

  hp_bin_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .en_i(en), .half_period_i(hp),
    .irq_idx_i(idx), .irq_div_i(dv), .pol_inv_i(pinv), .irq_en_i(ien),
    .irq_clr_i(clr), .bin_idx_o(bin), .bin_stb_o(stb), .drive_pol_o(pol),
    .irq_pulse_o(irq), .irq_flag_o(flag)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  always @(posedge clk) begin
    int len, nb, hit;
    if (!rst_n) begin
      m_bin = 0; m_cnt = 0; m_pc = 0; m_hp = 8; m_stb = 0; m_irq = 0; m_flag = 0;
    end else begin
      m_stb = 0; m_irq = 0;
      if (!en) begin
        m_bin = 0; m_cnt = 0; m_pc = 0;
        m_hp = (int'(hp) < 8) ? 8 : int'(hp);
      end else if (tick) begin
        len = (m_bin % 8 == 7) ? (m_hp / 8 + m_hp % 8) : (m_hp / 8);
        if (m_cnt + 1 >= len) begin
          m_cnt = 0;
          nb = (m_bin + 1) % 16;
          if (m_bin % 8 == 7) m_hp = (int'(hp) < 8) ? 8 : int'(hp);
          if (nb == 0) m_pc = (m_pc + 1 >= int'(dv)) ? 0 : m_pc + 1;
          hit = (idx < 8) ? int'(nb % 8 == int'(idx)) : int'(nb == int'(idx));
          if (hit != 0 && m_pc == 0 && ien) m_irq = 1;
          m_stb = 1;
          m_bin = nb;
        end else m_cnt++;
      end
      if (m_irq != 0) m_flag = 1;
      else if (clr) m_flag = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 bin_idx", int'(bin), m_bin);
      check("R5 bin_stb", int'(stb), m_stb);
      check("R6 drive_pol", int'(pol), (m_bin / 8) ^ int'(pinv));
      check("R7 irq_pulse", int'(irq), m_irq);
      check("R10 irq_flag", int'(flag), m_flag);
      if (irq) irq_seen++;
      if (stb) stb_seen++;
    end
  end

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic start(int h, int ix, int d, bit ie);
    @(negedge clk) en = 1'b0;
    hp = 16'(h); idx = 4'(ix); dv = 8'(d); ien = ie;
    @(negedge clk) en = 1'b1;
    irq_seen = 0; stb_seen = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset bin", int'(bin), 0);
    check("R1 reset stb", int'(stb), 0);
    check("R1 reset flag", int'(flag), 0);
    rst_n = 1'b1;

    // R7 low index: two hits per period, 3 periods of 40 ticks
    start(20, 2, 1, 1);
    ticks(120);
    check("R7 idx2 count", irq_seen, 6);
    check("R5 strobe count", stb_seen, 48);
    check("R10 flag set", int'(flag), 1);
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    check("R10 flag cleared", int'(flag), 0);

    // R7 high index: one hit per period
    start(20, 11, 1, 1);
    ticks(120);
    check("R7 idx11 count", irq_seen, 3);

    // R8 divider 3 over 6 periods
    start(20, 5, 3, 1);
    ticks(240);
    check("R8 div3 count", irq_seen, 4);

    // R9 gated
    start(20, 3, 0, 0);
    ticks(80);
    check("R9 gated count", irq_seen, 0);

    // R3 clamp
    start(3, 0, 1, 1);
    ticks(16);
    check("R3 clamp strobes", stb_seen, 16);

    // R2 / R4: bin timing and deferred half-period load
    start(20, 0, 1, 0);
    ticks(5);
    hp = 16'd40;
    ticks(9);
    check("R2 bin before last", int'(bin), 7);
    ticks(5);
    check("R2 remainder bin", int'(bin), 7);
    ticks(1);
    check("R4 old half kept", int'(bin), 8);
    ticks(35);
    check("R4 new half length", int'(bin), 15);
    pinv = 1'b1;
    ticks(5);
    check("R4 wrap", int'(bin), 0);
    check("R6 inverted pol", int'(pol), 1);
    pinv = 1'b0;

    // R1 disable mid run
    ticks(7);
    @(negedge clk) en = 1'b0;
    @(negedge clk);
    check("R1 disabled bin", int'(bin), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule